// File: doc/BRIEF.md
# CPU Processor Status Word

This block is the processor status word of a 32-bit CPU core. It keeps the four arithmetic condition flags (zero, sign, overflow, carry), a sticky saturation flag, and three control bits: NMI-in-service, exception-in-service and maskable-interrupt disable. It also decides, in the same cycle as a request, whether a maskable interrupt or a non-maskable interrupt may be taken.

The execute stage drives the flag-update strobes. The pipeline's system-register write drives a full-word software load. The trap logic reports NMI and exception acknowledges. The interrupt controller presents its highest pending requests and reads back the accept decisions.

A software load becomes visible on the cycle after it is presented, and acceptance during the load cycle still uses the old disable bit. When a load and a hardware event fall in the same cycle, the load wins, and the event's in-service bit is set one cycle later. Until that bit is set, the pending event blocks acceptance.

Top module: `cpu_status_word`

## Requirements
- R1: After reset the word reads 0x00000020: only the interrupt-disable bit (bit 5) is 1, so no maskable interrupt is accepted.
- R2: Bits 31 to 8 always read 0, even after a software load whose data has ones there.
- R3: A software load (`sw_load`=1) copies `sw_data[7:0]` into bits 7..0. The new value is visible from the following cycle.
- R4: With `alu_flag_we`=1, the flags zero (bit 0), sign (bit 1), overflow (bit 2) and carry (bit 3) all take the values of `alu_zero`, `alu_sign`, `alu_ovf` and `alu_carry` in one cycle. With `alu_flag_we`=0 they hold.
- R5: The saturation flag (bit 4) is set by `sat_event`. It stays 1 through later flag updates that have no `sat_event`. Only a software load with bit 4 = 0 clears it.
- R6: `nmi_ack` sets NMI-in-service (bit 7). `exc_ack` sets exception-in-service (bit 6). Both stay set until a software load changes them.
- R7: `mi_accept` is 1 only when `mi_req` is 1, bit 5 is 0, bit 7 is 0 and no NMI set is pending. Bit 6 has no effect on it.
- R8: `nmi_accept` is 1 only when `nmi_req` is 1, bit 7 is 0 and no NMI set is pending. Bits 5 and 6 have no effect on it.
- R9: If a software load coincides with an ALU update, a saturation event or an acknowledge, the next word equals the load data. A coinciding `nmi_ack` or `exc_ack` then sets its bit on the first cycle without a load, and a pending NMI set blocks both accepts until then.
- R10: In the cycle a load is presented, acceptance uses the pre-load bit 5. A load that clears bit 5 lets a maskable request through only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_flag_we | input | 1 | Strobe to update zero, sign, overflow and carry |
| alu_zero | input | 1 | Zero result |
| alu_sign | input | 1 | Negative result |
| alu_ovf | input | 1 | Signed overflow |
| alu_carry | input | 1 | Carry or borrow |
| sat_event | input | 1 | A saturating operation saturated |
| sw_load | input | 1 | Software load of the whole word |
| sw_data | input | 32 | Data for the software load |
| nmi_ack | input | 1 | NMI acknowledged |
| exc_ack | input | 1 | Exception taken |
| mi_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| status_word | output | 32 | Current status word |
| mi_accept | output | 1 | Maskable request accepted this cycle |
| nmi_accept | output | 1 | NMI request accepted this cycle |

## Verification
Flag updates are tried with several zero, sign, overflow and carry combinations, with and without the update strobe. This separates a joint four-bit write from a held value. Saturation is set, then followed by plain updates, and then cleared by loads. This shows whether the bit is sticky and whether anything other than a load can clear it. Requests are presented under each combination of the disable, exception and NMI bits, and in the cycles around a load and around a load that collides with an acknowledge. This shows which bit gates which request, and in which cycle each change takes effect.

// File: rtl/psw_pkg.sv
// Package: shared widths, field positions and reset value of the status word.
// Assumes the low byte layout (MSB to LSB): nmi-in-service, exc-in-service,
// irq-disable, saturated, carry, overflow, sign, zero.
package psw_pkg;
    localparam int WORD_W   = 32;
    localparam int FLAG_W   = 8;
    localparam int RSV_W    = WORD_W - FLAG_W;

    localparam int POS_Z    = 0;
    localparam int POS_S    = 1;
    localparam int POS_OV   = 2;
    localparam int POS_CY   = 3;
    localparam int POS_SAT  = 4;
    localparam int POS_ID   = 5;
    localparam int POS_EP   = 6;
    localparam int POS_NP   = 7;

    localparam logic [FLAG_W-1:0] FLAGS_RESET = 8'h20;

    typedef struct packed {
        logic np;
        logic ep;
        logic id;
        logic sat;
        logic cy;
        logic ov;
        logic s;
        logic z;
    } psw_flags_t;
endpackage

// File: rtl/psw_arith_flags.sv
// Module: arithmetic condition flags and the sticky saturation flag.
// Assumes a software load has priority over ALU and saturation updates.
module psw_arith_flags
    import psw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alu_flag_we,
    input  logic [3:0] alu_cozs,     // {carry, ovf, sign, zero}
    input  logic       sat_event,
    input  logic       sw_load,
    input  logic [4:0] sw_bits,      // {sat, cy, ov, s, z}
    output logic [4:0] arith_q       // {sat, cy, ov, s, z}
);
    logic [3:0] cozs_q;
    logic       sat_q;

    // Purpose: update the four condition flags from the ALU or a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cozs_q <= FLAGS_RESET[3:0];
        else if (sw_load)
            cozs_q <= sw_bits[3:0];
        else if (alu_flag_we)
            cozs_q <= alu_cozs;
    end

    // Purpose: sticky saturation flag, cleared only by a software load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_q <= FLAGS_RESET[POS_SAT];
        else if (sw_load)
            sat_q <= sw_bits[4];
        else if (sat_event)
            sat_q <= 1'b1;
    end

    assign arith_q = {sat_q, cozs_q};

    assert_sat_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !sw_load) |=> sat_q);
    assert_sat_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_event && !sw_load) |=> sat_q);
endmodule

// File: rtl/psw_ctrl_flags.sv
// Module: NMI-in-service, exception-in-service and interrupt-disable bits.
// Assumes an acknowledge that coincides with a software load is held pending
// and applied on the first following cycle without a load.
module psw_ctrl_flags
    import psw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_load,
    input  logic [2:0] sw_bits,     // {np, ep, id}
    input  logic       nmi_ack,
    input  logic       exc_ack,
    output logic [2:0] ctrl_q,      // {np, ep, id}
    output logic       np_pending
);
    logic np_q, ep_q, id_q;
    logic pend_np_q, pend_ep_q;

    // Purpose: load or set the control bits and track deferred sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_q      <= FLAGS_RESET[POS_NP];
            ep_q      <= FLAGS_RESET[POS_EP];
            id_q      <= FLAGS_RESET[POS_ID];
            pend_np_q <= 1'b0;
            pend_ep_q <= 1'b0;
        end else if (sw_load) begin
            np_q      <= sw_bits[2];
            ep_q      <= sw_bits[1];
            id_q      <= sw_bits[0];
            pend_np_q <= pend_np_q | nmi_ack;
            pend_ep_q <= pend_ep_q | exc_ack;
        end else begin
            if (nmi_ack || pend_np_q) np_q <= 1'b1;
            if (exc_ack || pend_ep_q) ep_q <= 1'b1;
            pend_np_q <= 1'b0;
            pend_ep_q <= 1'b0;
        end
    end

    assign ctrl_q     = {np_q, ep_q, id_q};
    assign np_pending = pend_np_q;

    assert_pend_np_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_np_q && !sw_load) |=> np_q);
    assert_pend_ep_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_ep_q && !sw_load) |=> ep_q);
endmodule

// File: rtl/psw_irq_gate.sv
// Module: combinational interrupt acceptance.
// Assumes the pending NMI set counts as NMI in service.
module psw_irq_gate (
    input  logic mi_req,
    input  logic nmi_req,
    input  logic id,
    input  logic np,
    input  logic np_pending,
    output logic mi_accept,
    output logic nmi_accept
);
    logic nmi_busy;

    // Purpose: form the accept decisions from the current control bits.
    always_comb begin
        nmi_busy   = np | np_pending;
        mi_accept  = mi_req & ~id & ~nmi_busy;
        nmi_accept = nmi_req & ~nmi_busy;
    end
endmodule

// File: rtl/cpu_status_word.sv
// Module: top of the processor status word.
// Assumes the reserved upper bits are never stored; they are driven as 0.
module cpu_status_word
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_flag_we,
    input  logic              alu_zero,
    input  logic              alu_sign,
    input  logic              alu_ovf,
    input  logic              alu_carry,
    input  logic              sat_event,
    input  logic              sw_load,
    input  logic [WORD_W-1:0] sw_data,
    input  logic              nmi_ack,
    input  logic              exc_ack,
    input  logic              mi_req,
    input  logic              nmi_req,
    output logic [WORD_W-1:0] status_word,
    output logic              mi_accept,
    output logic              nmi_accept
);
    logic [4:0] arith_q;
    logic [2:0] ctrl_q;
    logic       np_pending;
    psw_flags_t flags;

    psw_arith_flags u_arith (
        .clk         (clk),
        .rst_n       (rst_n),
        .alu_flag_we (alu_flag_we),
        .alu_cozs    ({alu_carry, alu_ovf, alu_sign, alu_zero}),
        .sat_event   (sat_event),
        .sw_load     (sw_load),
        .sw_bits     (sw_data[POS_SAT:POS_Z]),
        .arith_q     (arith_q)
    );

    psw_ctrl_flags u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_load    (sw_load),
        .sw_bits    (sw_data[POS_NP:POS_ID]),
        .nmi_ack    (nmi_ack),
        .exc_ack    (exc_ack),
        .ctrl_q     (ctrl_q),
        .np_pending (np_pending)
    );

    // Purpose: assemble the architectural flag byte from both units.
    always_comb begin
        flags = psw_flags_t'({ctrl_q, arith_q});
    end

    assign status_word = {{RSV_W{1'b0}}, flags};

    psw_irq_gate u_gate (
        .mi_req     (mi_req),
        .nmi_req    (nmi_req),
        .id         (flags.id),
        .np         (flags.np),
        .np_pending (np_pending),
        .mi_accept  (mi_accept),
        .nmi_accept (nmi_accept)
    );

    assert_load_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> status_word[FLAG_W-1:0] == $past(sw_data[FLAG_W-1:0]));
    assert_alu_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_flag_we && !sw_load) |=>
            status_word[POS_CY:POS_Z] == $past({alu_carry, alu_ovf, alu_sign, alu_zero}));
    assert_nmi_sets_np_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !sw_load) |=> status_word[POS_NP]);
    assert_mi_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mi_accept |-> (!status_word[POS_ID] && !status_word[POS_NP]));
    assert_nmi_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_accept |-> !status_word[POS_NP]);
    assert_reserved_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> status_word[WORD_W-1:FLAG_W] == '0);
endmodule

// File: tb/cpu_status_word_test.sv
module cpu_status_word_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alu_flag_we, alu_zero, alu_sign, alu_ovf, alu_carry, sat_event;
    logic        sw_load, nmi_ack, exc_ack, mi_req, nmi_req;
    logic [31:0] sw_data;
    logic [31:0] status_word;
    logic        mi_accept, nmi_accept;

    always #2.5 clk = ~clk;

    cpu_status_word uut (
        .clk(clk), .rst_n(rst_n), .alu_flag_we(alu_flag_we), .alu_zero(alu_zero),
        .alu_sign(alu_sign), .alu_ovf(alu_ovf), .alu_carry(alu_carry),
        .sat_event(sat_event), .sw_load(sw_load), .sw_data(sw_data),
        .nmi_ack(nmi_ack), .exc_ack(exc_ack), .mi_req(mi_req), .nmi_req(nmi_req),
        .status_word(status_word), .mi_accept(mi_accept), .nmi_accept(nmi_accept)
    );

    typedef struct {
        logic [31:0] word;
        logic        mi;
        logic        nmi;
        string       word_tag;
        string       acc_tag;
    } exp_t;

    exp_t queue_q[$];
    int checks = 0;
    int fails  = 0;

    // staged stimulus
    logic        s_we, s_z, s_s, s_o, s_c, s_sat, s_ld, s_na, s_ea, s_mr, s_nr;
    logic [31:0] s_d;
    // reference state
    logic [7:0]  m_w;
    logic        m_pnp, m_pep;
    string       prev_tag;

    task automatic clear_stim();
        {s_we, s_z, s_s, s_o, s_c, s_sat, s_ld, s_na, s_ea, s_mr, s_nr} = '0;
        s_d = '0;
    endtask

    task automatic step(input string tag);
        exp_t e;
        logic [7:0] n;
        @(posedge clk);
        #1;
        alu_flag_we = s_we; alu_zero = s_z; alu_sign = s_s; alu_ovf = s_o;
        alu_carry = s_c; sat_event = s_sat; sw_load = s_ld; sw_data = s_d;
        nmi_ack = s_na; exc_ack = s_ea; mi_req = s_mr; nmi_req = s_nr;
        e.word     = {24'h0, m_w};
        e.mi       = s_mr & ~m_w[5] & ~m_w[7] & ~m_pnp;
        e.nmi      = s_nr & ~m_w[7] & ~m_pnp;
        e.word_tag = prev_tag;
        e.acc_tag  = tag;
        queue_q.push_back(e);
        prev_tag = tag;
        if (s_ld) begin
            n = s_d[7:0];
            m_pnp = m_pnp | s_na;
            m_pep = m_pep | s_ea;
        end else begin
            n = m_w;
            if (s_we) n[3:0] = {s_c, s_o, s_s, s_z};
            if (s_sat) n[4] = 1'b1;
            if (s_na || m_pnp) n[7] = 1'b1;
            if (s_ea || m_pep) n[6] = 1'b1;
            m_pnp = 1'b0;
            m_pep = 1'b0;
        end
        m_w = n;
        clear_stim();
    endtask

    // monitor: compare design outputs against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (queue_q.size() > 0) begin
                exp_t e;
                e = queue_q.pop_front();
                checks += 3;
                if (status_word !== e.word) begin
                    fails++;
                    $display("FAIL %s word: got %h expected %h", e.word_tag, status_word, e.word);
                end
                if (mi_accept !== e.mi) begin
                    fails++;
                    $display("FAIL %s mi_accept: got %b expected %b", e.acc_tag, mi_accept, e.mi);
                end
                if (nmi_accept !== e.nmi) begin
                    fails++;
                    $display("FAIL %s nmi_accept: got %b expected %b", e.acc_tag, nmi_accept, e.nmi);
                end
            end
        end
    end

    initial begin
        #(5 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_stim();
        alu_flag_we = 0; alu_zero = 0; alu_sign = 0; alu_ovf = 0; alu_carry = 0;
        sat_event = 0; sw_load = 0; sw_data = '0; nmi_ack = 0; exc_ack = 0;
        mi_req = 0; nmi_req = 0;
        m_w = 8'h20; m_pnp = 0; m_pep = 0; prev_tag = "R1";
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset word, maskable blocked, NMI open
        s_mr = 1; s_nr = 1; step("R1");
        step("R1");
        // R2/R3: load with reserved ones
        s_ld = 1; s_d = 32'hFFFF_FF0F; step("R2");
        step("R3");
        s_ld = 1; s_d = 32'h0000_0000; step("R3");
        // R4: several flag patterns, then hold
        s_we = 1; s_z = 1; step("R4");
        s_we = 1; s_s = 1; s_c = 1; step("R4");
        s_we = 1; s_o = 1; s_z = 1; s_c = 1; step("R4");
        s_z = 0; s_s = 1; step("R4");
        // R5: sticky saturation
        s_sat = 1; step("R5");
        s_we = 1; step("R5");
        s_we = 1; s_s = 1; step("R5");
        s_ld = 1; s_d = 32'h0000_0013; step("R5");
        s_ld = 1; s_d = 32'h0000_0003; step("R5");
        // R7: EP does not block, ID=0
        s_mr = 1; s_ea = 1; step("R7");
        s_mr = 1; s_nr = 1; step("R7");
        s_mr = 1; step("R6");
        // R10: set ID, then clear it while requesting
        s_ld = 1; s_d = 32'h0000_0020; step("R10");
        s_mr = 1; s_ld = 1; s_d = 32'h0000_0000; step("R10");
        s_mr = 1; step("R10");
        // R6/R8: NMI enters service, blocks both
        s_na = 1; s_nr = 1; step("R6");
        s_mr = 1; s_nr = 1; step("R8");
        s_mr = 1; s_nr = 1; step("R8");
        // restore by load, with ID=1 NMI still open
        s_ld = 1; s_d = 32'h0000_0020; step("R8");
        s_mr = 1; s_nr = 1; step("R8");
        // R9: collision of load with ALU, sat and acks
        s_ld = 1; s_d = 32'h0000_0000; s_na = 1; s_ea = 1; s_we = 1; s_c = 1; s_sat = 1;
        step("R9");
        s_mr = 1; s_nr = 1; step("R9");
        s_mr = 1; s_nr = 1; step("R9");
        // R9: pending survives a second load
        s_ld = 1; s_d = 32'h0000_0000; step("R9");
        s_ld = 1; s_d = 32'h0000_0000; s_na = 1; step("R9");
        s_ld = 1; s_d = 32'h0000_0001; s_nr = 1; step("R9");
        s_nr = 1; step("R9");
        step("R9");
        step("R2");
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule